// File: doc/BRIEF.md
# SMBus Target Block-Read Responder

This block is the target side of an SMBus general-purpose block read. It watches the sampled SCL and SDA lines for a start condition. It acknowledges its own write address and checks that the command code equals a configured value. After a repeated start it checks the read address. It then shifts out a byte count, that many bytes from a small data buffer, and a PEC byte that it computes itself. The block drives SDA only through an open-drain pull-low output, and it never stretches SCL.

Once the write address has been acknowledged, the transaction is active. From then on the block classifies every way it can end, including master misbehaviour and stuck lines, into one 4-bit completion code. It reports the code with a single-cycle done pulse. The transaction-type code for this kind of transfer is 0101. The code set also holds 0001 (PEC error), which this responder never reports because it sends the PEC rather than checking one. SCL and SDA are assumed to be synchronised to `clk` already, and the configured count is assumed never to exceed the buffer depth.

Top module: `smb_blkrd_target`

## Requirements
- R1: During and after reset, done_o is 0, status_o is 0000 and sda_pull_o is 0 (SDA released).
- R2: The write address byte {own_addr_i, 0} is acknowledged by pulling SDA low in the ninth clock. Any other first byte, including {own_addr_i, 1}, is left unacknowledged, gives no done pulse and leaves status_o unchanged.
- R3: A command byte equal to cmd_code_i is acknowledged. Any other command byte is NACKed and ends the transaction with status 0011 (hardware NACK).
- R4: If the block releases SDA to NACK but SDA is sampled low in that acknowledge clock (a collision), the status is 0010 (protocol error).
- R5: The read address byte after the repeated start must have bits [7:1] equal to rd_addr_i. When rd_bit_chk_i is 1, bit 0 must also be 1; when it is 0, bit 0 is ignored. On a mismatch the byte is NACKed and the status is 0010.
- R6: The block transmits MSB first: the count byte_cnt_i, then data bytes 1..count (data byte j is buf_data_i[8j-1:8j-8]), then the PEC. The PEC is a CRC-8 with polynomial 0x07 and initial value 0, taken over the write address, command, read address, count and data bytes in bus order.
- R7: A NACK on the PEC followed by a stop gives status 0000. An ACK on the PEC gives 0010. Status 0001 is never reported.
- R8: A master NACK on the count or on any data byte ends the transaction with status 0100 (external NACK) and releases SDA.
- R9: Once active, a stop or start before the PEC acknowledge gives status 0010. This covers a stop mid-byte, a repeated start mid-byte, a stop in place of the repeated start, and a stop on a byte boundary before all bytes are sent.
- R10: A second SCL rising edge after the PEC acknowledge clock without a stop (further clocking) gives status 0010.
- R11: While active, SCL low for TMO_CYC consecutive clocks gives 0101 and SDA low for TMO_CYC clocks gives 0110. If both expire in the same cycle, 0101 is reported.
- R12: Each transaction that becomes active gives exactly one done_o pulse lasting one cycle. status_o changes only together with that pulse and holds until the next one.
- R13: sda_pull_o only begins pulling low while SCL has been low, and it is released in the cycle done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain) |
| own_addr_i | input | 7 | Target address of the write phase |
| rd_addr_i | input | 7 | Expected address after the repeated start |
| cmd_code_i | input | 8 | Expected command code |
| rd_bit_chk_i | input | 1 | 1 requires read bit 0 of the repeated-start address to be 1 |
| byte_cnt_i | input | $clog2(MAXB+1) | Number of data bytes to return |
| buf_data_i | input | MAXB*8 | Data buffer, byte 1 in the low bits |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 4 | Completion code of the last transaction |

## Verification
The clock-low and data-low timeout counters can expire in the same cycle, and only one code can be reported. The bench provokes this after an acknowledged write address by dropping SCL and SDA on the same sampling edge and holding both low past the threshold. It expects exactly one done pulse carrying 0101. Separate runs that hold only SCL low, and only SDA low with SCL high, confirm that each counter still produces its own code when it expires alone.

// File: rtl/smb_br_pkg.sv
// Shared types for the SMBus block-read responder.
// Assumes: nothing beyond IEEE 1800-2017.
package smb_br_pkg;

    // Completion codes reported on status_o
    typedef enum logic [3:0] {
        CS_OK      = 4'b0000,
        CS_PECERR  = 4'b0001,
        CS_PROTO   = 4'b0010,
        CS_HWNACK  = 4'b0011,
        CS_EXTNACK = 4'b0100,
        CS_SCLTMO  = 4'b0101,
        CS_SDATMO  = 4'b0110
    } cstat_e;

    // Transaction progress
    typedef enum logic [2:0] {
        PH_IDLE, PH_WADDR, PH_CMD, PH_RSWAIT, PH_RADDR, PH_TX, PH_ENDWAIT
    } phase_e;

    // Bus events decoded from two successive line samples
    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } busev_t;

    // One byte step of CRC-8, polynomial x^8+x^2+x+1, MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/smb_br_linemon.sv
// Line monitor: registers SCL/SDA, decodes edges and start/stop,
// and runs one low-time counter per line.
// Assumes: scl_i/sda_i already synchronised to clk; TMO_CYC >= 2.
module smb_br_linemon
    import smb_br_pkg::*;
#(
    parameter int TMO_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output busev_t     ev,
    output logic [1:0] tmo      // [0] SCL low expired, [1] SDA low expired
);
    localparam int TW = $clog2(TMO_CYC + 1);

    logic [1:0] cur_q, prv_q;   // bit 0 = SCL, bit 1 = SDA

    // Two-deep line history for edge decoding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= 2'b11;
            prv_q <= 2'b11;
        end else begin
            cur_q <= {sda_i, scl_i};
            prv_q <= cur_q;
        end
    end

    assign ev.rise  = cur_q[0] & ~prv_q[0];
    assign ev.fall  = ~cur_q[0] & prv_q[0];
    assign ev.start = cur_q[0] & prv_q[0] & prv_q[1] & ~cur_q[1];
    assign ev.stop  = cur_q[0] & prv_q[0] & ~prv_q[1] & cur_q[1];
    assign ev.sda   = cur_q[1];

    for (genvar g = 0; g < 2; g++) begin : g_low
        logic [TW-1:0] cnt_q;
        // Saturating count of consecutive low samples on this line
        always_ff @(posedge clk) begin
            if (!rst_n || cur_q[g]) begin
                cnt_q <= '0;
            end else if (cnt_q != TW'(TMO_CYC)) begin
                cnt_q <= cnt_q + TW'(1);
            end
        end
        assign tmo[g] = ~cur_q[g] && (cnt_q == TW'(TMO_CYC - 1));
    end
endmodule

// File: rtl/smb_br_fsm.sv
// Transaction sequencer: receives address/command/read-address bytes,
// transmits count, data and PEC, and resolves the completion code.
// Assumes: byte_cnt_i <= MAXB; ev/tmo from smb_br_linemon.
module smb_br_fsm
    import smb_br_pkg::*;
#(
    parameter int MAXB = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  busev_t                       ev,
    input  logic [1:0]                   tmo,
    input  logic [6:0]                   own_addr_i,
    input  logic [6:0]                   rd_addr_i,
    input  logic [7:0]                   cmd_code_i,
    input  logic                         rd_bit_chk_i,
    input  logic [$clog2(MAXB+1)-1:0]    byte_cnt_i,
    input  logic [MAXB*8-1:0]            buf_data_i,
    output logic                         pull_o,
    output logic                         done_o,
    output logic [3:0]                   status_o
);
    localparam int KW = $clog2(MAXB + 2);

    phase_e        ph;
    logic [3:0]    bi;          // SCL rises seen in the current 9-clock frame
    logic [6:0]    sh;
    logic          ack_ok;
    logic [KW-1:0] k;           // 0 = count, 1..N data, N+1 = PEC
    logic [7:0]    crc;
    logic [7:0]    rxb, txb;
    logic          pec_slot, active, fin;
    cstat_e        fin_st;

    assign rxb      = {sh, ev.sda};
    assign pec_slot = (int'(k) == int'(byte_cnt_i) + 1);
    assign active   = (ph != PH_IDLE) && (ph != PH_WADDR);

    // Select the byte being transmitted
    always_comb begin
        txb = crc;
        if (k == '0) begin
            txb = 8'(byte_cnt_i);
        end else begin
            for (int j = 0; j < MAXB; j++) begin
                if (int'(k) == j + 1 && !pec_slot) txb = buf_data_i[8*j +: 8];
            end
        end
    end

    // Resolve whether this cycle ends the transaction, in priority order
    always_comb begin
        fin    = 1'b0;
        fin_st = CS_OK;
        if (active) begin
            if (tmo[0]) begin
                fin = 1'b1; fin_st = CS_SCLTMO;
            end else if (tmo[1]) begin
                fin = 1'b1; fin_st = CS_SDATMO;
            end else if (ev.stop) begin
                fin = 1'b1; fin_st = (ph == PH_ENDWAIT) ? CS_OK : CS_PROTO;
            end else if (ev.start && ph != PH_RSWAIT) begin
                fin = 1'b1; fin_st = CS_PROTO;
            end else if (ev.rise) begin
                if (ph == PH_RSWAIT || ph == PH_ENDWAIT) begin
                    if (bi != 4'd0) begin fin = 1'b1; fin_st = CS_PROTO; end
                end else if (bi == 4'd8) begin
                    unique case (ph)
                        PH_CMD:   if (!ack_ok) begin
                                      fin = 1'b1; fin_st = ev.sda ? CS_HWNACK : CS_PROTO;
                                  end
                        PH_RADDR: if (!ack_ok) begin fin = 1'b1; fin_st = CS_PROTO; end
                        PH_TX:    if (pec_slot) begin
                                      if (!ev.sda) begin fin = 1'b1; fin_st = CS_PROTO; end
                                  end else if (ev.sda) begin
                                      fin = 1'b1; fin_st = CS_EXTNACK;
                                  end
                        default:  ;
                    endcase
                end
            end
        end
    end

    // Phase, bit counter, shift, CRC and SDA drive updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_IDLE; bi <= '0; sh <= '0; ack_ok <= 1'b0; k <= '0;
            crc <= '0; pull_o <= 1'b0; done_o <= 1'b0; status_o <= CS_OK;
        end else begin
            done_o <= 1'b0;
            if (fin) begin
                done_o <= 1'b1; status_o <= fin_st; ph <= PH_IDLE; pull_o <= 1'b0;
            end else if (ev.start && (ph == PH_IDLE || ph == PH_WADDR)) begin
                ph <= PH_WADDR; bi <= '0; crc <= '0; pull_o <= 1'b0;
            end else if (ev.start && ph == PH_RSWAIT) begin
                ph <= PH_RADDR; bi <= '0;
            end else if (ev.stop && ph == PH_WADDR) begin
                ph <= PH_IDLE; pull_o <= 1'b0;
            end else if (ev.rise && ph != PH_IDLE) begin
                if (ph == PH_RSWAIT || ph == PH_ENDWAIT) begin
                    bi <= 4'd1;
                end else if (bi == 4'd8) begin
                    bi <= '0;
                    unique case (ph)
                        PH_WADDR: ph <= ack_ok ? PH_CMD : PH_IDLE;
                        PH_CMD:   ph <= PH_RSWAIT;
                        PH_RADDR: begin ph <= PH_TX; k <= '0; end
                        PH_TX:    if (pec_slot) ph <= PH_ENDWAIT;
                                  else k <= k + KW'(1);
                        default:  ;
                    endcase
                end else begin
                    sh <= rxb[6:0];
                    bi <= bi + 4'd1;
                    if (bi == 4'd7) begin
                        unique case (ph)
                            PH_WADDR: begin
                                ack_ok <= (rxb == {own_addr_i, 1'b0});
                                crc    <= crc8_step(crc, rxb);
                            end
                            PH_CMD: begin
                                ack_ok <= (rxb == cmd_code_i);
                                crc    <= crc8_step(crc, rxb);
                            end
                            PH_RADDR: begin
                                ack_ok <= (rxb[7:1] == rd_addr_i) && (rxb[0] || !rd_bit_chk_i);
                                crc    <= crc8_step(crc, rxb);
                            end
                            PH_TX:    if (!pec_slot) crc <= crc8_step(crc, txb);
                            default:  ;
                        endcase
                    end
                end
            end else if (ev.fall) begin
                unique case (ph)
                    PH_TX:    pull_o <= (bi < 4'd8) ? ~txb[3'(4'd7 - bi)] : 1'b0;
                    PH_WADDR, PH_CMD, PH_RADDR: pull_o <= (bi == 4'd8) && ack_ok;
                    default:  pull_o <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_blkrd_target.sv
// Top of the SMBus target block-read responder: line monitor plus
// transaction sequencer. Assumes a synchronous active-low reset and
// line samples already in the clk domain.
module smb_blkrd_target #(
    parameter int MAXB    = 4,
    parameter int TMO_CYC = 1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_pull_o,
    input  logic [6:0]                own_addr_i,
    input  logic [6:0]                rd_addr_i,
    input  logic [7:0]                cmd_code_i,
    input  logic                      rd_bit_chk_i,
    input  logic [$clog2(MAXB+1)-1:0] byte_cnt_i,
    input  logic [MAXB*8-1:0]         buf_data_i,
    output logic                      done_o,
    output logic [3:0]                status_o
);
    smb_br_pkg::busev_t ev;
    logic [1:0]         tmo;

    smb_br_linemon #(.TMO_CYC(TMO_CYC)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .ev(ev), .tmo(tmo)
    );

    smb_br_fsm #(.MAXB(MAXB)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ev(ev), .tmo(tmo),
        .own_addr_i(own_addr_i), .rd_addr_i(rd_addr_i), .cmd_code_i(cmd_code_i),
        .rd_bit_chk_i(rd_bit_chk_i), .byte_cnt_i(byte_cnt_i), .buf_data_i(buf_data_i),
        .pull_o(sda_pull_o), .done_o(done_o), .status_o(status_o)
    );
endmodule

// File: rtl/smb_br_chk.sv
// Property checker for smb_blkrd_target, attached by bind below.
// Assumes: synchronous active-low reset held for at least one clock.
module smb_br_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_pull_o,
    input logic       done_o,
    input logic [3:0] status_o
);
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_status_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(status_o));

    assert_no_pec_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> status_o != 4'b0001);

    assert_release_on_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !sda_pull_o);

    assert_pull_while_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> (!scl_i && !$past(scl_i)));
endmodule

bind smb_blkrd_target smb_br_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
    .done_o(done_o), .status_o(status_o)
);

// File: tb/sim_smb_blkrd_target.sv
// Bench: bit-bangs an SMBus master against the responder and sweeps counts,
// policies and misbehaviours; expected bytes and codes are computed here.
module sim_smb_blkrd_target;
    localparam int MAXB = 4;
    localparam int HB   = 5;
    localparam logic [6:0] OWN = 7'h35;
    localparam logic [6:0] RDA = 7'h35;
    localparam logic [7:0] CMD = 8'hC3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic pull, done_o, rdchk;
    logic [3:0] status_o;
    logic [2:0] cnt_i;
    logic [MAXB*8-1:0] dbuf;
    logic sda_line;

    int vec = 0, miss = 0, done_cnt = 0;
    logic [3:0] last_st = 4'h0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~pull;

    smb_blkrd_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(pull),
        .own_addr_i(OWN), .rd_addr_i(RDA), .cmd_code_i(CMD), .rd_bit_chk_i(rdchk),
        .byte_cnt_i(cnt_i), .buf_data_i(dbuf), .done_o(done_o), .status_o(status_o)
    );

    // Record every completion pulse
    always @(negedge clk) if (rst_n && done_o) begin done_cnt++; last_st = status_o; end

    task automatic chk(input string r, input int act, input int exp);
        vec++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c ^ d;
        for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic w(input int n); repeat (n) @(negedge clk); endtask
    task automatic m_start;  sda_m = 0; w(HB); scl_m = 0; w(HB); endtask
    task automatic m_rstart; sda_m = 1; w(HB); scl_m = 1; w(HB); sda_m = 0; w(HB); scl_m = 0; w(HB); endtask
    task automatic m_stop;   sda_m = 0; w(HB); scl_m = 1; w(HB); sda_m = 1; w(HB); endtask
    task automatic m_bit(input logic b, output logic r);
        sda_m = b; w(HB); scl_m = 1; w(HB); r = sda_line; scl_m = 0;
    endtask
    task automatic wbyte(input logic [7:0] v, input logic ackdrv, output logic a);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(v[i], r);
        m_bit(ackdrv, a);
    endtask
    task automatic rbyte(input logic ackb, output logic [7:0] v);
        logic r;
        for (int i = 0; i < 8; i++) begin m_bit(1'b1, r); v = {v[6:0], r}; end
        m_bit(ackb, r);
    endtask

    task automatic finish_chk(input string tag, input int exp_cnt, input int exp_st);
        w(20);
        chk({tag, " done pulses R12"}, done_cnt, exp_cnt);
        chk({tag, " status"}, int'(last_st), exp_st);
    endtask

    // Full block read with selectable master behaviour
    task automatic do_read(input int n, input int nack_at, input bit pec_ack, input bit extra,
                           input int stop_at, input logic [7:0] rab, input int exp_st, input string tag);
        logic a; logic [7:0] v, e, c;
        bit rab_ok;
        cnt_i = 3'(n); done_cnt = 0; c = 8'h00;
        rab_ok = (rab[7:1] == RDA) && (rab[0] || !rdchk);
        m_start;
        wbyte({OWN, 1'b0}, 1'b1, a); chk({tag, " addr ack R2"}, a, 0); c = crc_b(c, {OWN, 1'b0});
        wbyte(CMD, 1'b1, a);         chk({tag, " cmd ack R3"}, a, 0);  c = crc_b(c, CMD);
        m_rstart;
        wbyte(rab, 1'b1, a);         chk({tag, " raddr ack R5"}, a, rab_ok ? 0 : 1); c = crc_b(c, rab);
        if (rab_ok) begin
            for (int idx = 0; idx <= n + 1; idx++) begin
                logic ab;
                if (idx == stop_at) break;
                e  = (idx == 0) ? 8'(n) : (idx <= n) ? dbuf[8*(idx-1) +: 8] : c;
                ab = (idx == nack_at) ? 1'b1 : (idx == n + 1) ? !pec_ack : 1'b0;
                rbyte(ab, v);
                chk({tag, " byte R6"}, v, e);
                if (idx <= n) c = crc_b(c, e);
                if (idx == nack_at) break;
            end
            if (extra) rbyte(1'b1, v);
        end
        m_stop;
        finish_chk(tag, 1, exp_st);
    endtask

    // Stall a line after the write address has been acknowledged
    task automatic tmo_case(input int mode, input int exp_st, input string tag);
        logic a, r;
        done_cnt = 0;
        m_start; wbyte({OWN, 1'b0}, 1'b1, a); m_bit(1'b1, r);
        scl_m = 1; w(HB);
        if (mode == 0) begin scl_m = 0; w(1100); scl_m = 1; w(HB); end
        else if (mode == 1) begin scl_m = 0; sda_m = 0; w(1100); scl_m = 1; w(HB); sda_m = 1; end
        else begin scl_m = 0; w(2); sda_m = 0; w(2); scl_m = 1; w(1100); sda_m = 1; end
        w(HB);
        finish_chk(tag, 1, exp_st);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miss++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end

    initial begin
        logic a, r;
        rdchk = 1'b1; cnt_i = '0; dbuf = '0;
        w(4);
        chk("reset done R1", done_o, 0);
        chk("reset status R1", status_o, 0);
        chk("reset pull R1", pull, 0);
        rst_n = 1'b1; w(4);

        // R6 R7: sweep counts and both read-bit policies
        for (int pol = 0; pol < 2; pol++) begin
            for (int n = 0; n <= MAXB; n++) begin
                rdchk = pol[0];
                for (int j = 0; j < MAXB; j++) dbuf[8*j +: 8] = 8'(n * 37 + j * 91 + pol * 13 + 5);
                do_read(n, -1, 0, 0, -1, {RDA, 1'b1}, 0, "R6 R7 normal read");
            end
        end

        // R2: foreign address and read-direction own address are ignored
        done_cnt = 0;
        m_start; wbyte({7'h11, 1'b0}, 1'b1, a); chk("R2 foreign addr no ack", a, 1); m_stop;
        m_start; wbyte({OWN, 1'b1}, 1'b1, a);   chk("R2 read-dir addr no ack", a, 1); m_stop;
        finish_chk("R2 ignored", 0, 0);

        // R3: wrong command
        done_cnt = 0;
        m_start; wbyte({OWN, 1'b0}, 1'b1, a); wbyte(8'h3C, 1'b1, a);
        chk("R3 cmd nack", a, 1); m_stop;
        finish_chk("R3 hw nack", 1, 3);

        // R4: collision on the NACK slot
        done_cnt = 0;
        m_start; wbyte({OWN, 1'b0}, 1'b1, a); wbyte(8'h3C, 1'b0, a); m_stop;
        finish_chk("R4 collision", 1, 2);

        // R5: read address checks
        rdchk = 1'b1; dbuf = 32'h0403_0201;
        do_read(2, -1, 0, 0, -1, {RDA, 1'b0}, 2, "R5 read bit 0 with check");
        do_read(2, -1, 0, 0, -1, {7'h12, 1'b1}, 2, "R5 addr mismatch");
        rdchk = 1'b0;
        do_read(2, -1, 0, 0, -1, {RDA, 1'b0}, 0, "R5 read bit ignored");
        rdchk = 1'b1;

        // R8: master NACK on count and on each data byte
        dbuf = 32'h5A_C3_81_7E;
        for (int j = 0; j <= 3; j++) do_read(3, j, 0, 0, -1, {RDA, 1'b1}, 4, "R8 ext nack");

        // R7: ACK on PEC; R10: clocking past PEC
        do_read(2, -1, 1, 0, -1, {RDA, 1'b1}, 2, "R7 pec acked");
        do_read(2, -1, 0, 1, -1, {RDA, 1'b1}, 2, "R10 extra clocks");

        // R9: stop on byte boundary before count done (next MSB is 1)
        dbuf = 32'hA5A5_A5A5;
        do_read(3, -1, 0, 0, 2, {RDA, 1'b1}, 2, "R9 early stop");

        // R9: stop instead of repeated start
        done_cnt = 0;
        m_start; wbyte({OWN, 1'b0}, 1'b1, a); wbyte(CMD, 1'b1, a); m_stop;
        finish_chk("R9 stop before restart", 1, 2);

        // R9: stop and restart in the middle of the command byte
        done_cnt = 0;
        m_start; wbyte({OWN, 1'b0}, 1'b1, a);
        m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r); m_stop;
        finish_chk("R9 mid-byte stop", 1, 2);
        done_cnt = 0;
        m_start; wbyte({OWN, 1'b0}, 1'b1, a);
        m_bit(1'b1, r); m_bit(1'b1, r); m_rstart; m_stop;
        finish_chk("R9 mid-byte restart", 1, 2);

        // R11: timeouts, alone and coinciding
        tmo_case(0, 5, "R11 scl low");
        tmo_case(2, 6, "R11 sda low");
        tmo_case(1, 5, "R11 both same cycle");

        // R12: status held with no new transaction
        w(50);
        chk("R12 status held", status_o, 5);
        chk("R13 pull released idle", pull, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end
endmodule